// File: doc/BRIEF.md
# Byte-Wide Counter Data Port with Snapshot Latch

This block sits between an 8-bit data port and one 16-bit timer channel. Software writes a 16-bit reload value through the port and reads the channel's count back through it, one byte at a time. The byte order depends on the programmed transfer mode:

- low byte only;
- high byte only;
- low byte followed by high byte.

Reloads are handed to the counting logic with a one-cycle load strobe. The counting logic itself lies outside this block.

A snapshot command copies the live count into a holding register. Both bytes can then be read from one consistent value while the counter keeps running. The snapshot is only a copy taken off to the side, so taking it never disturbs the live count. The snapshot holds until it has been read out completely for the current transfer mode, or until a new mode command arrives.

Two state machines carry the byte ordering:

- **Write machine.** States: `WS_LOW` and `WS_HIGH`.
  - `WS_LOW -> WS_HIGH` on the first write in low-then-high mode.
  - `WS_HIGH -> WS_LOW` on the second write, which also fires the load.
  - Any mode command returns the machine to `WS_LOW`.
- **Read machine.** States: `RS_LIVE_LO`, `RS_LIVE_HI`, `RS_SNAP_LO` and `RS_SNAP_HI`.
  - A snapshot command moves either live state to `RS_SNAP_LO`.
  - In low-then-high mode a read advances `_LO -> _HI`.
  - A read from `RS_SNAP_HI` returns to `RS_LIVE_LO`.
  - In single-byte modes, one read moves any snapshot state to `RS_LIVE_LO`.
  - A mode command forces `RS_LIVE_LO`.

Top module: `ctr_byte_port`

## Requirements
- R1: While reset is held, and in the cycle after, `reload_val` is 0 and `reload_load` is 0. The transfer mode is low-then-high (code 3). Both byte orderings start at the low byte. No snapshot is held.
- R2: In low-only mode (`cmd_access` = 1), each data write sets `reload_val` to {8'h00, `wdata`} and pulses `reload_load` in the next cycle. Reads return bits 7:0 of the source.
- R3: In high-only mode (`cmd_access` = 2), each data write sets `reload_val` to {`wdata`, 8'h00} and pulses `reload_load` in the next cycle. Reads return bits 15:8 of the source.
- R4: In low-then-high mode (`cmd_access` = 3), the first write is held as the low byte without any load. The second write sets `reload_val` to {second, first} and only then pulses `reload_load`.
- R5: With no snapshot held, `rdata` shows the live `live_count`. In low-then-high mode successive reads alternate between bits 7:0 and bits 15:8.
- R6: A command with `cmd_access` = 0 copies `live_count` into the snapshot register. Reads then return snapshot bytes, unchanged by later changes of `live_count`. The first byte returned is the low byte in low-then-high mode.
- R7: The snapshot is released, and reads return to the live count, after one read in a single-byte mode or after two reads in low-then-high mode.
- R8: A snapshot command issued while a snapshot is still held has no effect: neither the held value nor the read position changes.
- R9: A mode command (`cmd_access` != 0) stores the new mode, drops any snapshot, and returns both the read and the write ordering to the low byte.
- R10: When `cmd_wr` is high, any `data_wr` or `data_rd` in the same cycle is ignored: no load, no change to the reload value, no advance of the read ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe for this channel |
| cmd_access | input | 2 | Command access field: 0 snapshot, 1 low only, 2 high only, 3 low then high |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe (the current `rdata` is consumed) |
| wdata | input | 8 | Data-port write byte |
| live_count | input | 16 | Running count from the counting logic |
| reload_val | output | 16 | Assembled reload value |
| reload_load | output | 1 | One-cycle strobe: `reload_val` has just been updated |
| rdata | output | 8 | Byte currently presented on the data port |

## Verification
A read machine left in the wrong state shows up at once: `rdata` presents the wrong half of the count, or the live value where the snapshot belongs. Because `rdata` is combinational from the state, the error is visible in the cycle after the faulty transition. A write machine out of step shows up on the next write, either as a missing or extra `reload_load` or as swapped bytes in `reload_val`. A snapshot released too early or too late is exposed by moving `live_count` away from the captured value, so live and held bytes differ in every read.

// File: rtl/ctr_port_pkg.sv
package ctr_port_pkg;

    // Command access field; 0 is the snapshot command
    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LOW  = 2'b01,
        ACC_HIGH = 2'b10,
        ACC_BOTH = 2'b11
    } acc_e;

    typedef enum logic {
        WS_LOW,
        WS_HIGH
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_LIVE_LO,
        RS_LIVE_HI,
        RS_SNAP_LO,
        RS_SNAP_HI
    } rd_state_e;

endpackage

// File: rtl/cp_cmd_decode.sv
module cp_cmd_decode
    import ctr_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [1:0] cmd_access,
    output acc_e       mode,
    output logic       mode_set,
    output logic       snap_req
);

    acc_e acc_in;

    always_comb begin
        acc_in   = acc_e'(cmd_access);
        mode_set = cmd_wr && (acc_in != ACC_SNAP);
        snap_req = cmd_wr && (acc_in == ACC_SNAP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= ACC_BOTH;
        end else if (mode_set) begin
            mode <= acc_in;
        end
    end

endmodule

// File: rtl/cp_write_fsm.sv
module cp_write_fsm
    import ctr_port_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              mode,
    input  logic              mode_set,
    input  logic              cmd_busy,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  reload_val,
    output logic              reload_load
);

    wr_state_e         state_q, state_d;
    logic [BYTE_W-1:0] low_q, low_d;
    logic [CNT_W-1:0]  val_d;
    logic              load_d;
    logic              take;

    assign take = data_wr && !cmd_busy;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (mode_set) begin
            state_d = WS_LOW;
        end else if (take && mode == ACC_BOTH) begin
            unique case (state_q)
                WS_LOW:  state_d = WS_HIGH;
                WS_HIGH: state_d = WS_LOW;
                default: state_d = WS_LOW;
            endcase
        end
    end

    // Output data
    always_comb begin
        val_d  = reload_val;
        load_d = 1'b0;
        low_d  = low_q;
        if (take) begin
            unique case (mode)
                ACC_LOW: begin
                    val_d  = {{BYTE_W{1'b0}}, wdata};
                    load_d = 1'b1;
                end
                ACC_HIGH: begin
                    val_d  = {wdata, {BYTE_W{1'b0}}};
                    load_d = 1'b1;
                end
                ACC_BOTH: begin
                    if (state_q == WS_LOW) begin
                        low_d = wdata;
                    end else begin
                        val_d  = {wdata, low_q};
                        load_d = 1'b1;
                    end
                end
                default: begin
                    load_d = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val  <= '0;
            reload_load <= 1'b0;
            low_q       <= '0;
        end else begin
            reload_val  <= val_d;
            reload_load <= load_d;
            low_q       <= low_d;
        end
    end

endmodule

// File: rtl/cp_read_fsm.sv
module cp_read_fsm
    import ctr_port_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              mode,
    input  logic              mode_set,
    input  logic              snap_req,
    input  logic              cmd_busy,
    input  logic              data_rd,
    input  logic [CNT_W-1:0]  live_count,
    output logic [BYTE_W-1:0] rdata,
    output logic              snap_valid
);

    rd_state_e        state_q, state_d;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] src;
    logic             pick_hi;
    logic             take;
    logic             single;

    assign take   = data_rd && !cmd_busy;
    assign single = (mode == ACC_LOW) || (mode == ACC_HIGH);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_LIVE_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (mode_set) begin
            state_d = RS_LIVE_LO;
        end else if (snap_req) begin
            unique case (state_q)
                RS_LIVE_LO, RS_LIVE_HI: state_d = RS_SNAP_LO;
                RS_SNAP_LO, RS_SNAP_HI: state_d = state_q;
                default:                state_d = RS_LIVE_LO;
            endcase
        end else if (take) begin
            if (single) begin
                state_d = RS_LIVE_LO;
            end else begin
                unique case (state_q)
                    RS_LIVE_LO: state_d = RS_LIVE_HI;
                    RS_LIVE_HI: state_d = RS_LIVE_LO;
                    RS_SNAP_LO: state_d = RS_SNAP_HI;
                    RS_SNAP_HI: state_d = RS_LIVE_LO;
                    default:    state_d = RS_LIVE_LO;
                endcase
            end
        end
    end

    // Snapshot capture, only on entry to a held state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (!mode_set && snap_req && !snap_valid) begin
            snap_q <= live_count;
        end
    end

    // Outputs
    always_comb begin
        snap_valid = (state_q == RS_SNAP_LO) || (state_q == RS_SNAP_HI);
        src        = snap_valid ? snap_q : live_count;
        unique case (mode)
            ACC_LOW:  pick_hi = 1'b0;
            ACC_HIGH: pick_hi = 1'b1;
            ACC_BOTH: pick_hi = (state_q == RS_LIVE_HI) || (state_q == RS_SNAP_HI);
            default:  pick_hi = 1'b0;
        endcase
        rdata = pick_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

endmodule

// File: rtl/ctr_byte_port.sv
module ctr_byte_port
    import ctr_port_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_access,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_count,
    output logic [CNT_W-1:0]  reload_val,
    output logic              reload_load,
    output logic [BYTE_W-1:0] rdata
);

    acc_e mode;
    logic mode_set;
    logic snap_req;
    logic snap_valid;

    cp_cmd_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_access (cmd_access),
        .mode       (mode),
        .mode_set   (mode_set),
        .snap_req   (snap_req)
    );

    cp_write_fsm #(.BYTE_W(BYTE_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .mode_set    (mode_set),
        .cmd_busy    (cmd_wr),
        .data_wr     (data_wr),
        .wdata       (wdata),
        .reload_val  (reload_val),
        .reload_load (reload_load)
    );

    cp_read_fsm #(.BYTE_W(BYTE_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .mode_set   (mode_set),
        .snap_req   (snap_req),
        .cmd_busy   (cmd_wr),
        .data_rd    (data_rd),
        .live_count (live_count),
        .rdata      (rdata),
        .snap_valid (snap_valid)
    );

endmodule

// File: rtl/cp_port_chk.sv
module cp_port_chk #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic [1:0]        cmd_access,
    input logic              data_rd,
    input logic [CNT_W-1:0]  reload_val,
    input logic              reload_load,
    input logic [BYTE_W-1:0] rdata,
    input logic              snap_valid
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (reload_val == '0) && !reload_load);

    // R4
    reload_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_val != $past(reload_val)) |-> reload_load);

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && !cmd_wr && !data_rd) |=> $stable(rdata));

    // R8
    second_snap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && cmd_wr && cmd_access == 2'b00) |=> ($stable(rdata) && snap_valid));

    // R9
    mode_drops_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_access != 2'b00) |=> !snap_valid);

    // R10
    cmd_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !reload_load);

endmodule

bind ctr_byte_port cp_port_chk #(.BYTE_W(BYTE_W)) u_port_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_access  (cmd_access),
    .data_rd     (data_rd),
    .reload_val  (reload_val),
    .reload_load (reload_load),
    .rdata       (rdata),
    .snap_valid  (snap_valid)
);

// File: tb/tb_ctr_byte_port.sv
`timescale 1ns/1ps
module tb_ctr_byte_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [1:0]  cmd_access = 2'b00;
    logic        data_wr = 1'b0;
    logic        data_rd = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [15:0] live_count = 16'h0000;
    logic [15:0] reload_val;
    logic        reload_load;
    logic [7:0]  rdata;

    int total = 0;
    int bad = 0;
    string req = "R1";
    bit started = 0;
    bit done = 0;

    // reference model state
    int m_mode = 3;
    bit m_wtog = 0;
    bit m_rtog = 0;
    bit m_held = 0;
    int m_snap = 0;
    int m_low = 0;
    int m_reload = 0;
    bit m_load = 0;

    always #2.5 clk = ~clk;

    ctr_byte_port dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_access(cmd_access),
        .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata),
        .live_count(live_count), .reload_val(reload_val),
        .reload_load(reload_load), .rdata(rdata)
    );

    always @(posedge clk) begin
        started = 1;
        m_load = 0;
        if (!rst_n) begin
            m_mode = 3; m_wtog = 0; m_rtog = 0; m_held = 0;
            m_snap = 0; m_low = 0; m_reload = 0;
        end else if (cmd_wr) begin
            if (cmd_access != 0) begin
                m_mode = cmd_access; m_wtog = 0; m_rtog = 0; m_held = 0;
            end else if (!m_held) begin
                m_held = 1; m_snap = live_count; m_rtog = 0;
            end
        end else begin
            if (data_wr) begin
                if (m_mode == 1) begin m_reload = wdata; m_load = 1; end
                else if (m_mode == 2) begin m_reload = wdata * 256; m_load = 1; end
                else if (!m_wtog) begin m_low = wdata; m_wtog = 1; end
                else begin m_reload = wdata * 256 + m_low; m_load = 1; m_wtog = 0; end
            end
            if (data_rd) begin
                if (m_mode != 3) begin m_held = 0; m_rtog = 0; end
                else if (!m_rtog) m_rtog = 1;
                else begin m_rtog = 0; m_held = 0; end
            end
        end
    end

    function automatic int exp_rdata();
        int src = m_held ? m_snap : int'(live_count);
        bit hi = (m_mode == 2) || (m_mode == 3 && m_rtog);
        return hi ? (src >> 8) & 255 : src & 255;
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            total++;
            if (int'(rdata) != exp_rdata()) begin
                bad++;
                $display("FAIL %s rdata got %h exp %h", req, rdata, exp_rdata());
            end
            total++;
            if (int'(reload_val) != m_reload) begin
                bad++;
                $display("FAIL %s reload_val got %h exp %h", req, reload_val, m_reload[15:0]);
            end
            total++;
            if (reload_load != m_load) begin
                bad++;
                $display("FAIL %s reload_load got %b exp %b", req, reload_load, m_load);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic cmd(input logic [1:0] acc);
        cmd_wr = 1; cmd_access = acc; tick(1); cmd_wr = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        data_wr = 1; wdata = b; tick(1); data_wr = 0;
    endtask

    task automatic rd();
        data_rd = 1; tick(1); data_rd = 0;
    endtask

    initial begin
        req = "R1"; tick(3); rst_n = 1; tick(2);
        req = "R4"; wr(8'h34); tick(1); wr(8'h12); tick(2);
        req = "R5"; live_count = 16'hABCD; tick(1); rd(); rd(); rd(); live_count = 16'h1357; tick(1);
        req = "R2"; cmd(2'b01); wr(8'h55); wr(8'hA0); rd(); tick(1);
        req = "R3"; cmd(2'b10); wr(8'h66); rd(); tick(1);
        req = "R6"; cmd(2'b11); live_count = 16'h1234; cmd(2'b00); live_count = 16'h9999; tick(2);
        rd();
        req = "R8"; live_count = 16'h7777; cmd(2'b00); tick(1);
        req = "R7"; rd(); tick(1); live_count = 16'h4321; tick(1);
        cmd(2'b01); live_count = 16'h0F0E; cmd(2'b00); live_count = 16'h2222; rd(); tick(1);
        cmd(2'b10); live_count = 16'h3C5A; cmd(2'b00); live_count = 16'h0000; rd(); tick(1);
        req = "R9"; cmd(2'b11); live_count = 16'h5A5A; cmd(2'b00); live_count = 16'h6B6B; rd();
        cmd(2'b11); tick(1); rd(); wr(8'hEE); cmd(2'b11); wr(8'h11); wr(8'h22); tick(1);
        req = "R10"; data_wr = 1; wdata = 8'h99; cmd(2'b01); data_wr = 0; tick(1);
        data_rd = 1; cmd(2'b11); data_rd = 0; tick(1);
        data_wr = 1; data_rd = 1; wdata = 8'h44; cmd(2'b00); data_wr = 0; data_rd = 0;
        live_count = 16'h8001; tick(1); rd(); rd(); tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog %s timeout got 0 exp 1", req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule